// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls thirteen general-purpose pins through a byte-wide register bus. Each pin has two control bytes. The drive byte sets the direction, the push-pull or open-drain choice, the pull resistor enable and selection, and the output level. The sense byte reads back the synchronized pin level and selects which edges raise an event. The pad is modelled only as digital signals: the pin input, the output value, the output enable, and three status outputs that describe the pull setting.

Edge events are collected in two write-one-to-clear status registers of uneven width. The first holds seven bits for pins 0 to 6. The second holds six bits for pins 7 to 12. Each status register has a mask register beside it. A single interrupt line goes to the host. It is high while any status bit is set and that bit's mask bit is clear. A host normally configures a pin, unmasks it, waits for the interrupt, reads both status bytes, and clears the bits it has handled.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is an input with its output enable low. Edge detection is disabled on every pin. Both mask registers read all ones for their width (0x7F and 0x3F). Both status registers read 0x00, and irq_o is low.
- R2: The drive byte of pin n is at address 0x4E44+n. Its fields are:
  - bit 5: direction (1 = output)
  - bit 4: drive type (1 = push-pull, 0 = open-drain)
  - bit 3: pull enable
  - bits 2:1: pull select (0 = 2k down, 1 = 2k up, 2 = 50k down, 3 = 50k up)
  - bit 0: output level

  Bits 7:6 read as 0. The pull outputs show bit 3 on pull_en_o, bit 1 on pull_up_o (pull up) and bit 2 on pull_weak_o (the 50k strength).
- R3: pin_o always carries the output level. pin_oe_o is high only when the direction is output and either the drive is push-pull or the level is 0. An open-drain pin at level 1 is therefore released.
- R4: The sense byte of pin n is at address 0x4E51+n. Bit 0 reads the pin level after a two-flop synchronizer. Bits 2:1 are the stored edge select. Bits 7:3 read as 0, and bit 0 ignores writes.
- R5: The edge select works as follows: 0 gives no events, 1 gives falling edges, 2 gives rising edges, and 3 gives both.
- R6: Status for pins 0 to 6 is in bits 6:0 of address 0x4E0B. Status for pins 7 to 12 is in bits 5:0 of address 0x4E0C. Unused upper bits read 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An edge in the same cycle as a clear keeps the bit set.
- R8: A detected edge sets its status bit whatever the mask is. Edges on other pins add to bits that are already pending.
- R9: The mask for pins 0 to 6 is in bits 6:0 of address 0x4E19. The mask for pins 7 to 12 is in bits 5:0 of address 0x4E1A. A mask bit of 1 suppresses that pin. irq_o is the OR over all pins of status AND NOT mask.
- R10: Read data appears on rdata_o in the cycle after re_i and is 0x00 otherwise. A read of any address outside the register map returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 13 | Pin input levels |
| pin_o | output | 13 | Pin output values |
| pin_oe_o | output | 13 | Pin output enables |
| pull_en_o | output | 13 | Pull resistor enabled |
| pull_up_o | output | 13 | Pull direction is up |
| pull_weak_o | output | 13 | Pull strength is the 50k setting |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Open-drain pin driven high.** A faulty design would drive the pin instead of releasing it.
- **Edge on a masked pin.** A design that gates status with the mask would lose the event and never interrupt after unmask.
- **Zero written to a pending status bit.** A design with plain write semantics would clear the bit.
- **Second edge while another bit is pending.** A design that overwrites status would drop the earlier pin.
- **Status bit in the six-bit group.** A design with the wrong pin-to-bit offset would put the bit in the wrong place.

Random mixes of configuration, pin toggles, clears and mask writes check every result against a bench model of both status groups and the interrupt line. Reads of holes in the map are also checked: unused status bits, and addresses just past the register ranges.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int G0_PINS  = 7;
  localparam int G1_PINS  = 6;
  localparam int NUM_PINS = G0_PINS + G1_PINS;

  localparam logic [ADDR_W-1:0] DRV_BASE  = 16'h4E44;
  localparam logic [ADDR_W-1:0] SNS_BASE  = 16'h4E51;
  localparam logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B;
  localparam logic [ADDR_W-1:0] MASK_BASE = 16'h4E19;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // field order matches drive byte bits 5:0
  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       level;
  } drv_cfg_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_edge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drv_we_i,
  input  logic       sns_we_i,
  input  logic [5:0] wdata_i,
  input  logic       pin_i,
  output logic [7:0] drv_byte_o,
  output logic [7:0] sns_byte_o,
  output logic       event_o,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       pull_en_o,
  output logic       pull_up_o,
  output logic       pull_weak_o
);
  drv_cfg_t   cfg_q;
  edge_mode_e edge_q;
  logic       lvl_s, lvl_d;
  logic       rise, fall;

  gpio_sync2 u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      edge_q <= EDGE_OFF;
      lvl_d  <= 1'b0;
    end else begin
      if (drv_we_i) cfg_q  <= drv_cfg_t'(wdata_i);
      if (sns_we_i) edge_q <= edge_mode_e'(wdata_i[2:1]);
      lvl_d <= lvl_s;
    end
  end

  assign rise    = lvl_s & ~lvl_d;
  assign fall    = ~lvl_s & lvl_d;
  assign event_o = (rise & ((edge_q == EDGE_RISE) | (edge_q == EDGE_BOTH)))
                 | (fall & ((edge_q == EDGE_FALL) | (edge_q == EDGE_BOTH)));

  assign drv_byte_o = {2'b00, cfg_q};
  assign sns_byte_o = {5'b00000, edge_q, lvl_s};

  // open-drain: drive only the low level
  assign pin_o       = cfg_q.level;
  assign pin_oe_o    = cfg_q.dir_out & (cfg_q.push_pull | ~cfg_q.level);
  assign pull_en_o   = cfg_q.pull_en;
  assign pull_up_o   = cfg_q.pull_sel[0];
  assign pull_weak_o = cfg_q.pull_sel[1];
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] event_i,
  input  logic             stat_we_i,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] status_q, mask_q, clr;

  assign clr = stat_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr) | event_i;  // new edge beats clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_weak_o,
  output logic                irq_o
);
  localparam int G1_LO = G0_PINS;

  logic [DATA_W-1:0]   drv_byte [NUM_PINS];
  logic [DATA_W-1:0]   sns_byte [NUM_PINS];
  logic [NUM_PINS-1:0] drv_we, sns_we, evt;
  logic [G0_PINS-1:0]  stat0, mask0;
  logic [G1_PINS-1:0]  stat1, mask1;
  logic                irq0, irq1;
  logic [DATA_W-1:0]   rd_next, rdata_q;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:6];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign drv_we[g] = we_i && (addr_i == DRV_BASE + ADDR_W'(g));
    assign sns_we[g] = we_i && (addr_i == SNS_BASE + ADDR_W'(g));

    gpio_pin_slice u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .drv_we_i   (drv_we[g]),
      .sns_we_i   (sns_we[g]),
      .wdata_i    (wdata_i[5:0]),
      .pin_i      (pin_i[g]),
      .drv_byte_o (drv_byte[g]),
      .sns_byte_o (sns_byte[g]),
      .event_o    (evt[g]),
      .pin_o      (pin_o[g]),
      .pin_oe_o   (pin_oe_o[g]),
      .pull_en_o  (pull_en_o[g]),
      .pull_up_o  (pull_up_o[g]),
      .pull_weak_o(pull_weak_o[g])
    );
  end

  gpio_irq_group #(.WIDTH(G0_PINS)) u_grp0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (evt[G0_PINS-1:0]),
    .stat_we_i(we_i && (addr_i == STAT_BASE)),
    .mask_we_i(we_i && (addr_i == MASK_BASE)),
    .wdata_i  (wdata_i[G0_PINS-1:0]),
    .status_o (stat0),
    .mask_o   (mask0),
    .irq_o    (irq0)
  );

  gpio_irq_group #(.WIDTH(G1_PINS)) u_grp1 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (evt[NUM_PINS-1:G1_LO]),
    .stat_we_i(we_i && (addr_i == STAT_BASE + ADDR_W'(1))),
    .mask_we_i(we_i && (addr_i == MASK_BASE + ADDR_W'(1))),
    .wdata_i  (wdata_i[G1_PINS-1:0]),
    .status_o (stat1),
    .mask_o   (mask1),
    .irq_o    (irq1)
  );

  assign irq_o = irq0 | irq1;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == DRV_BASE + ADDR_W'(i)) rd_next = drv_byte[i];
      if (addr_i == SNS_BASE + ADDR_W'(i)) rd_next = sns_byte[i];
    end
    if (addr_i == STAT_BASE)               rd_next = DATA_W'(stat0);
    if (addr_i == STAT_BASE + ADDR_W'(1))  rd_next = DATA_W'(stat1);
    if (addr_i == MASK_BASE)               rd_next = DATA_W'(mask0);
    if (addr_i == MASK_BASE + ADDR_W'(1))  rd_next = DATA_W'(mask1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_next : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic                re_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [G0_PINS-1:0]  stat0_i,
  input logic [G1_PINS-1:0]  stat1_i,
  input logic [G0_PINS-1:0]  mask0_i,
  input logic [G1_PINS-1:0]  mask1_i
);
  logic mapped;
  assign mapped = (addr_i >= DRV_BASE && addr_i < SNS_BASE + ADDR_W'(NUM_PINS))
               || addr_i == STAT_BASE || addr_i == STAT_BASE + ADDR_W'(1)
               || addr_i == MASK_BASE || addr_i == MASK_BASE + ADDR_W'(1);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> (rdata_o == '0));

  p_idle_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));

  p_stat0_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == STAT_BASE) |=> ((stat0_i & $past(stat0_i)) == $past(stat0_i)));

  p_stat1_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == STAT_BASE + ADDR_W'(1)) |=> ((stat1_i & $past(stat1_i)) == $past(stat1_i)));

  p_all_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask0_i && &mask1_i) |-> !irq_o);

  p_irq_has_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|stat0_i || |stat1_i));

  p_input_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DRV_BASE && !wdata_i[5]) |=> !pin_oe_o[0]);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .stat0_i (stat0),
  .stat1_i (stat1),
  .mask0_i (mask0),
  .mask1_i (mask1)
);

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata;
  logic [12:0] pins = '0;
  logic [12:0] pout, poe, pen, pup, pweak;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [5:0]  m_drv [13];
  logic [1:0]  m_edge [13];
  logic [12:0] m_stat = '0, m_mask = '1;

  always #10 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pins),
    .pin_o(pout), .pin_oe_o(poe), .pull_en_o(pen), .pull_up_o(pup),
    .pull_weak_o(pweak), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic logic edge_hit(logic [1:0] m, logic o, logic n);
    return (m[1] && !o && n) || (m[0] && o && !n);
  endfunction

  function automatic logic exp_oe(logic [5:0] c);
    return c[5] && (c[4] || !c[0]);
  endfunction

  task automatic check_irq_state();
    logic [7:0] d;
    rd(16'h4E0B, d); check("R6 status group0", d, {1'b0, m_stat[6:0]});
    rd(16'h4E0C, d); check("R6 status group1", d, {2'b0, m_stat[12:7]});
    check("R9 irq", irq, |(m_stat & ~m_mask));
  endtask

  task automatic do_drv(int p, logic [7:0] v);
    logic [7:0] d;
    wr(16'h4E44 + 16'(p), v); m_drv[p] = v[5:0];
    rd(16'h4E44 + 16'(p), d);
    check("R2 drive readback", d, {2'b0, m_drv[p]});
    check("R2 pull outputs", {pen[p], pweak[p], pup[p]}, {m_drv[p][3], m_drv[p][2], m_drv[p][1]});
    check("R3 output enable", poe[p], exp_oe(m_drv[p]));
    check("R3 output value", pout[p], m_drv[p][0]);
  endtask

  task automatic do_edge(int p, logic [7:0] v);
    logic [7:0] d;
    wr(16'h4E51 + 16'(p), v); m_edge[p] = v[2:1];
    rd(16'h4E51 + 16'(p), d);
    check("R4 sense readback", d, {5'b0, m_edge[p], pins[p]});
  endtask

  task automatic do_toggle(int p);
    logic [7:0] d;
    logic o;
    o = pins[p];
    @(negedge clk); pins[p] = ~o;
    repeat (4) @(negedge clk);
    if (edge_hit(m_edge[p], o, ~o)) m_stat[p] = 1'b1;  // R5, R8
    rd(16'h4E51 + 16'(p), d);
    check("R4 synced level", d[0], pins[p]);
    check_irq_state();
  endtask

  task automatic do_clear(int g, logic [7:0] v);
    wr(16'h4E0B + 16'(g), v);
    if (g == 0) m_stat[6:0] &= ~v[6:0]; else m_stat[12:7] &= ~v[5:0];  // R7
    check_irq_state();
  endtask

  task automatic do_mask(int g, logic [7:0] v);
    logic [7:0] d;
    wr(16'h4E19 + 16'(g), v);
    if (g == 0) m_mask[6:0] = v[6:0]; else m_mask[12:7] = v[5:0];
    rd(16'h4E19 + 16'(g), d);
    check("R9 mask readback", d, g == 0 ? {1'b0, m_mask[6:0]} : {2'b0, m_mask[12:7]});
    check_irq_state();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 13; i++) begin m_drv[i] = '0; m_edge[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 oe after reset", poe, 13'h0);
    check("R1 irq after reset", irq, 0);
    rd(16'h4E0B, d); check("R1 status0", d, 8'h00);
    rd(16'h4E0C, d); check("R1 status1", d, 8'h00);
    rd(16'h4E19, d); check("R1 mask0", d, 8'h7F);
    rd(16'h4E1A, d); check("R1 mask1", d, 8'h3F);
    rd(16'h4E44 + 16'd5, d); check("R1 drive byte", d, 8'h00);
    rd(16'h4E51 + 16'd9, d); check("R1 edge off", d, 8'h00);

    // R10 holes in the map
    rd(16'h4E30, d); check("R10 unmapped 4E30", d, 8'h00);
    rd(16'h4E5E, d); check("R10 unmapped 4E5E", d, 8'h00);
    rd(16'h4E0D, d); check("R10 unmapped 4E0D", d, 8'h00);
    rd(16'h4E1B, d); check("R10 unmapped 4E1B", d, 8'h00);

    // R2 upper bits dropped, last pin, full pull
    do_drv(12, 8'hFF);
    // R3 open-drain release and drive
    do_drv(3, 8'h21);
    check("R3 open-drain high released", poe[3], 0);
    do_drv(3, 8'h20);
    check("R3 open-drain low driven", poe[3], 1);
    do_drv(3, 8'h31);
    check("R3 push-pull high driven", poe[3], 1);
    do_drv(3, 8'h01);
    check("R3 input not driven", poe[3], 0);

    // R5/R8 masked edge in group1, accumulate with group0
    do_edge(8, 8'h04);
    do_toggle(8);
    check("R8 masked pin still pending", m_stat[8], 1);
    check("R9 masked pending no irq", irq, 0);
    do_edge(2, 8'h02);
    do_toggle(2);
    check("R5 rise ignored in falling mode", m_stat[2], 0);
    do_toggle(2);
    check("R8 second pin accumulates", m_stat[2] && m_stat[8], 1);
    do_toggle(8);  // falling edge, rising mode: no change

    // R7 writing zero keeps, one clears
    do_clear(1, 8'h00);
    check("R7 zero write keeps", m_stat[8], 1);
    do_mask(0, 8'h7B);
    check("R9 unmasked pending irq", irq, 1);
    do_clear(0, 8'h04);
    check("R9 irq drops after clear", irq, 0);
    do_clear(1, 8'h02);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, p;
      op = $urandom_range(0, 4);
      p  = $urandom_range(0, 12);
      case (op)
        0: do_drv(p, 8'($urandom));
        1: do_edge(p, 8'($urandom));
        2: do_toggle(p);
        3: do_clear($urandom_range(0, 1), 8'($urandom));
        default: do_mask($urandom_range(0, 1), 8'($urandom));
      endcase
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule